// File: doc/BRIEF.md
# Per-Class Memory Request Throttle

This block sits on the path from a processor core to the memory interface and slows each outgoing memory request by a number of cycles that depends on the class of service of the running task. The class identifier used here is the same one that selects the cache capacity mask, so no separate tag is needed. Software programs a table with one delay entry per class, and it may reprogram that table while tasks run. The throttle does not measure bandwidth. Stretching the gap before each request gives coarse, indirect control over how much memory bandwidth a core can draw.

A request arrives when the block is idle and `req_valid` is high. In that cycle the block reads the delay of the current class and records the class. It then keeps `mem_valid` and `req_ready` low until the delay has run out, and after that it forwards the request. A delay of zero forwards the request in the same cycle through combinational logic. The upstream source keeps `req_valid` and `req_data` steady until the handshake completes.

Top module: `mbt_throttle`

## Requirements
- R1: Reset sets every class delay to zero. A synchronous reset applied mid-run clears any delay programmed before it, so after reset a request of any class is forwarded in its arrival cycle.
- R2: When the recorded delay is D > 0, `mem_valid` first goes high exactly D cycles after the arrival cycle. The arrival cycle counts as cycle 0.
- R3: When the delay is 0, `mem_valid` follows `req_valid` in the arrival cycle. `mem_data` always equals `req_data` while `mem_valid` is high.
- R4: While the delay is counting, `mem_valid` and `req_ready` are both low.
- R5: The class is recorded at arrival. Changing `cur_cls` during the delay changes neither that request's delay nor its `mem_cls` output.
- R6: A configuration write that lands during a delay does not change the count in progress. This includes a write in the arrival cycle itself. The new value applies from the next request of that class.
- R7: Once the delay has expired, `req_ready` equals `mem_ready`. While `mem_ready` is low, `mem_valid` stays high and `mem_cls` stays unchanged.
- R8: A write to the entry of class k (`cfg_cls` = k) leaves the delays of all other classes unchanged.
- R9: A request that is presented in the cycle right after the previous handshake arrives in that cycle and starts its own full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the delay table |
| cfg_cls | input | CLS_W | Class entry to write |
| cfg_delay | input | DLY_W | Delay value in cycles |
| cur_cls | input | CLS_W | Class of the task currently running on the core |
| req_valid | input | 1 | Request from the core is valid |
| req_ready | output | 1 | Request accepted |
| req_data | input | DATA_W | Request payload |
| mem_valid | output | 1 | Request towards memory is valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_data | output | DATA_W | Payload towards memory |
| mem_cls | output | CLS_W | Class recorded for the forwarded request |

## Verification
The hardest situations to reach are the ones where something changes inside a single request's delay window: a table write to the same class, a class switch on the core, or memory backpressure right after the window ends. The stimulus task counts cycles from arrival. At chosen cycle offsets it issues a table write or a class change, and it holds `mem_ready` low for a set number of open cycles. It then checks the measured latency against the delay recorded at arrival. A table write in the arrival cycle itself, and back-to-back requests with `req_valid` held high, cover the edge between one request and the next.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
    localparam int MBT_CLS_W_DEF  = 3;
    localparam int MBT_DLY_W_DEF  = 8;
    localparam int MBT_DATA_W_DEF = 32;

    typedef enum logic [0:0] {
        GATE_IDLE = 1'b0,
        GATE_HOLD = 1'b1
    } gate_state_e;

    // Number of counted cycles after arrival before the gate opens.
    function automatic int first_count(input int delay);
        return (delay > 0) ? delay - 1 : 0;
    endfunction
endpackage

// File: rtl/mbt_delay_table.sv
module mbt_delay_table
    import mbt_pkg::*;
#(
    parameter int CLS_W = MBT_CLS_W_DEF,
    parameter int DLY_W = MBT_DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CLS_W-1:0] wr_cls,
    input  logic [DLY_W-1:0] wr_val,
    input  logic [CLS_W-1:0] rd_cls,
    output logic [DLY_W-1:0] rd_val
);
    localparam int NCLS = 1 << CLS_W;

    logic [DLY_W-1:0] slot [NCLS];

    for (genvar g = 0; g < NCLS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (wr_en && wr_cls == CLS_W'(g)) begin
                slot[g] <= wr_val;
            end
        end

        // R1: reset clears every entry
        p_reset_zero_r1: assert property (@(posedge clk) rst |=> slot[g] == '0);
        // R8: a write to another class leaves this entry alone
        p_other_keep_r8: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_cls != CLS_W'(g)) |=> $stable(slot[g]));
    end

    assign rd_val = slot[rd_cls];
endmodule

// File: rtl/mbt_gate.sv
module mbt_gate
    import mbt_pkg::*;
#(
    parameter int CLS_W = MBT_CLS_W_DEF,
    parameter int DLY_W = MBT_DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic [CLS_W-1:0] cur_cls,
    input  logic [DLY_W-1:0] cur_delay,
    output logic             pass_en,
    output logic [CLS_W-1:0] out_cls
);
    gate_state_e      state_q;
    logic [DLY_W-1:0] cnt_q;
    logic [CLS_W-1:0] cls_q;
    logic             fire;

    assign pass_en = (state_q == GATE_HOLD) ? (cnt_q == '0) : (cur_delay == '0);
    assign fire    = in_valid && pass_en && out_ready;
    assign out_cls = (state_q == GATE_HOLD) ? cls_q : cur_cls;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_IDLE;
            cnt_q   <= '0;
            cls_q   <= '0;
        end else begin
            unique case (state_q)
                GATE_IDLE: begin
                    if (in_valid && !fire) begin
                        state_q <= GATE_HOLD;
                        cls_q   <= cur_cls;
                        cnt_q   <= DLY_W'(first_count(int'(cur_delay)));
                    end
                end
                GATE_HOLD: begin
                    if (fire) begin
                        state_q <= GATE_IDLE;
                    end else if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= GATE_IDLE;
            endcase
        end
    end

    // R2: a nonzero delay loads delay-1 at arrival
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_IDLE && in_valid && cur_delay != '0)
        |=> (state_q == GATE_HOLD && cnt_q == $past(cur_delay) - 1'b1));
    // R6: the count only moves down by one per cycle, whatever the table does
    p_count_down_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_HOLD && cnt_q != '0)
        |=> (state_q == GATE_HOLD && cnt_q == $past(cnt_q) - 1'b1));
    // R5: the recorded class holds until the handshake
    p_cls_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_HOLD && !fire) |=> (state_q == GATE_HOLD && $stable(cls_q)));
    // R4: no request leaves while counting
    p_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_HOLD && cnt_q != '0) |-> !fire);
endmodule

// File: rtl/mbt_throttle.sv
module mbt_throttle
    import mbt_pkg::*;
#(
    parameter int CLS_W  = MBT_CLS_W_DEF,
    parameter int DLY_W  = MBT_DLY_W_DEF,
    parameter int DATA_W = MBT_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CLS_W-1:0]  cfg_cls,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [CLS_W-1:0]  cur_cls,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [DATA_W-1:0] mem_data,
    output logic [CLS_W-1:0]  mem_cls
);
    logic [DLY_W-1:0] cls_delay;
    logic             pass_en;

    mbt_delay_table #(.CLS_W(CLS_W), .DLY_W(DLY_W)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_cls (cfg_cls),
        .wr_val (cfg_delay),
        .rd_cls (cur_cls),
        .rd_val (cls_delay)
    );

    mbt_gate #(.CLS_W(CLS_W), .DLY_W(DLY_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .out_ready (mem_ready),
        .cur_cls   (cur_cls),
        .cur_delay (cls_delay),
        .pass_en   (pass_en),
        .out_cls   (mem_cls)
    );

    assign mem_valid = req_valid && pass_en;
    assign req_ready = pass_en && mem_ready;
    assign mem_data  = req_data;

    // R7: acceptance upstream only with memory ready
    p_ready_mem_r7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ready);
    // R7: a stalled forward stays offered with the same class
    p_stall_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_cls)));
    // R3: nothing is forwarded without a request
    p_no_ghost_r3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> req_valid);
endmodule

// File: tb/tb_mbt_throttle.sv
`timescale 1ns/1ps
module tb_mbt_throttle;
    localparam int CLS_W = 3;
    localparam int DLY_W = 8;
    localparam int DATA_W = 32;
    localparam int NCLS = 1 << CLS_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [CLS_W-1:0] cfg_cls = '0;
    logic [DLY_W-1:0] cfg_delay = '0;
    logic [CLS_W-1:0] cur_cls = '0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [DATA_W-1:0] req_data = '0;
    logic mem_valid;
    logic mem_ready = 1'b1;
    logic [DATA_W-1:0] mem_data;
    logic [CLS_W-1:0] mem_cls;

    always #2.5 clk = ~clk;

    mbt_throttle #(.CLS_W(CLS_W), .DLY_W(DLY_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cls(cfg_cls), .cfg_delay(cfg_delay),
        .cur_cls(cur_cls), .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_data(mem_data), .mem_cls(mem_cls)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    int m_dly [NCLS];
    bit m_busy = 0;
    int m_cnt = 0;
    int m_cls = 0;
    bit m_fire = 0;
    bit m_mv = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        bit e_open, e_mv, e_rr;
        int e_cls;
        #1;
        e_open = m_busy ? (m_cnt == 0) : (m_dly[cur_cls] == 0);
        e_mv = req_valid && e_open;
        e_rr = e_open && mem_ready;
        e_cls = m_busy ? m_cls : int'(cur_cls);
        if (!rst) begin
            check(mem_valid == e_mv, "R4", "mem_valid", int'(mem_valid), int'(e_mv));
            check(req_ready == e_rr, "R7", "req_ready", int'(req_ready), int'(e_rr));
            if (e_mv) begin
                check(int'(mem_cls) == e_cls, "R5", "mem_cls", int'(mem_cls), e_cls);
                check(mem_data == req_data, "R3", "mem_data", int'(mem_data), int'(req_data));
            end
        end
        m_mv = e_mv;
        m_fire = req_valid && e_rr;
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < NCLS; i++) m_dly[i] = 0;
            m_busy = 0; m_cnt = 0; m_cls = 0;
        end else begin
            if (!m_busy) begin
                if (req_valid && !m_fire) begin
                    m_busy = 1;
                    m_cls = int'(cur_cls);
                    m_cnt = (m_dly[cur_cls] == 0) ? 0 : m_dly[cur_cls] - 1;
                end
            end else if (m_fire) begin
                m_busy = 0;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end
            if (cfg_we) m_dly[cfg_cls] = int'(cfg_delay);
        end
        @(negedge clk);
    endtask

    task automatic write_cfg(input int c, input int v);
        cfg_we = 1; cfg_cls = CLS_W'(c); cfg_delay = DLY_W'(v);
        step();
        cfg_we = 0;
    endtask

    // Issue one request; measure cycles from arrival to the first mem_valid.
    task automatic do_req(input int cls, input int data, input int exp_lat,
                          input int chg_at, input int new_cls,
                          input int cfg_at, input int cfg_c, input int cfg_v,
                          input int stall, input bit keep_valid, input string req);
        int k = 0;
        int lat = -1;
        int opened = 0;
        req_valid = 1;
        req_data = DATA_W'(data);
        forever begin
            cur_cls = CLS_W'((chg_at >= 0 && k >= chg_at) ? new_cls : cls);
            cfg_we = (k == cfg_at);
            cfg_cls = CLS_W'(cfg_c);
            cfg_delay = DLY_W'(cfg_v);
            mem_ready = (opened >= stall);
            step();
            if (lat < 0 && m_mv) lat = k;
            if (m_mv) opened++;
            k++;
            if (m_fire) break;
        end
        cfg_we = 0;
        mem_ready = 1;
        req_valid = keep_valid;
        check(lat == exp_lat, req, "latency", lat, exp_lat);
    endtask

    initial begin
        for (int i = 0; i < NCLS; i++) m_dly[i] = 0;
        rst = 1;
        repeat (3) step();
        rst = 0;
        step();
        // R1: reset table, any class passes at once
        do_req(3, 32'h11, 0, -1, 0, -1, 0, 0, 0, 0, "R1");
        write_cfg(1, 10);
        write_cfg(2, 3);
        write_cfg(6, 1);
        // R2: class 1 delayed by 10, class 6 by 1
        do_req(1, 32'h22, 10, -1, 0, -1, 0, 0, 0, 0, "R2");
        do_req(6, 32'h23, 1, -1, 0, -1, 0, 0, 0, 0, "R2");
        // R7: backpressure after the delay
        do_req(2, 32'h33, 3, -1, 0, -1, 0, 0, 4, 0, "R7");
        // R5: class switch during the delay
        do_req(2, 32'h44, 3, 1, 1, -1, 0, 0, 0, 0, "R5");
        // R6: rewrite during count, then next request uses the new value
        do_req(1, 32'h55, 10, -1, 0, 2, 1, 2, 0, 0, "R6");
        do_req(1, 32'h56, 2, -1, 0, -1, 0, 0, 0, 0, "R6");
        // R6: write in the arrival cycle itself
        do_req(2, 32'h57, 3, -1, 0, 0, 2, 5, 0, 0, "R6");
        do_req(2, 32'h58, 5, -1, 0, -1, 0, 0, 0, 0, "R6");
        // R8: write class 5 only
        write_cfg(5, 7);
        do_req(4, 32'h66, 0, -1, 0, -1, 0, 0, 0, 0, "R8");
        do_req(5, 32'h67, 7, -1, 0, -1, 0, 0, 0, 0, "R8");
        // R3: zero delay with backpressure
        do_req(0, 32'h77, 0, -1, 0, -1, 0, 0, 2, 0, "R3");
        // R9: back-to-back with valid held high
        do_req(2, 32'h88, 5, -1, 0, -1, 0, 0, 0, 1, "R9");
        do_req(0, 32'h89, 0, -1, 0, -1, 0, 0, 0, 1, "R9");
        do_req(5, 32'h8a, 7, -1, 0, -1, 0, 0, 0, 0, "R9");
        step();
        // R1: mid-run reset clears programmed delays
        rst = 1;
        step();
        rst = 0;
        step();
        do_req(1, 32'h99, 0, -1, 0, -1, 0, 0, 0, 0, "R1");
        do_req(5, 32'h9a, 0, -1, 0, -1, 0, 0, 0, 0, "R1");
        step();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule